// File: doc/BRIEF.md
# Video Controller Port Unit

This block is the processor-facing front end of a tile-based video controller. It decodes reads and writes on a small port window into two ports: a control port and a data port.

A control-port write does one of three things. It can update a one-byte internal register. It can be the first half of an access setup. Or it can be the second half, which completes the 6-bit access command and the 16-bit access address. A data-port write is forwarded as a single-cycle write strobe to one of three memories: video RAM, colour RAM or vertical scroll RAM. The command picks the memory. The data is repacked for that memory, and the access address then steps forward by a programmable amount. A control-port read returns a status word carrying a DMA-busy flag.

The two-word setup is tracked by a two-state machine:

- In `SEQ_IDLE`, no setup is open. A control write whose bits 15:14 are not `10` moves the machine to `SEQ_HALF`. A control write with bits 15:14 equal to `10` is a register write and leaves the machine in `SEQ_IDLE`.
- In `SEQ_HALF`, any control write completes the setup and returns the machine to `SEQ_IDLE`. This holds even when the word looks like a register write.
- From either state, a control read, a data read or a data write forces the machine back to `SEQ_IDLE`.

The current command and address are driven out so that a neighbouring DMA engine can use them. Register writes are also broadcast for neighbouring logic to decode.

Top module: `vid_port_unit`

## Requirements
- R1: In `SEQ_IDLE`, a control write with bits 15:14 = `10` is a register write. One cycle later `reg_we` pulses, with `reg_sel` = bits 12:8 and `reg_data` = bits 7:0. Bit 13 has no effect. Register 0x0F sets the address step.
- R2: In `SEQ_IDLE`, any other control write loads command bits 1:0 from data bits 15:14 and address bits 13:0 from data bits 13:0, then enters `SEQ_HALF`.
- R3: In `SEQ_HALF`, every control write loads command bits 5:2 from data bits 7:4 and address bits 15:14 from data bits 1:0. No register write takes place, and the machine returns to `SEQ_IDLE`.
- R4: A control read, a data read or a data write returns the machine to `SEQ_IDLE`. The next control write is therefore taken as a first word.
- R5: Command code 1 in bits 3:0 writes video RAM at word address = access address bits 15:1. When access address bit 0 is 1, the two data bytes are swapped.
- R6: Command code 3 writes colour RAM at index = access address bits 6:1. The stored 9-bit value is {data[11:9], data[7:5], data[3:1]}.
- R7: Command code 5 writes scroll RAM at index = access address bits 6:1, storing data bits 9:0. An index of 40 or more produces no write and no address step.
- R8: Each data write that produces a memory write adds the register 0x0F value to the access address. A data write under any other command code has no effect.
- R9: A read returns its result on `bus_rdata` one cycle later. A control read returns 0x3400, with bit 1 equal to `dma_active`. A data read returns 0x0000.
- R10: A register 0x01 write with data bit 4 = 0 clears command bit 5. With bit 4 = 1, the command is left unchanged.
- R11: A byte-wide write puts its low byte on both halves of the word, and bus address bit 0 is ignored. Bus addresses 0x00–0x03 select the data port and 0x04–0x07 the control port. Addresses 0x08 and above are ignored.
- R12: After reset the command, access address, step, read data and all write strobes are zero, and the machine is in `SEQ_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset within the port window |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_byte | input | 1 | Byte-wide access (low byte valid) |
| dma_active | input | 1 | DMA busy flag from the DMA engine |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| cmd_code | output | 6 | Current access command |
| acc_addr | output | 16 | Current access address |
| reg_we | output | 1 | Register write pulse |
| reg_sel | output | 5 | Register number |
| reg_data | output | 8 | Register value |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 15 | Video RAM word address |
| vram_wdata | output | 16 | Video RAM data |
| cram_we | output | 1 | Colour RAM write strobe |
| cram_addr | output | 6 | Colour RAM index |
| cram_wdata | output | 9 | Packed colour |
| vsram_we | output | 1 | Scroll RAM write strobe |
| vsram_addr | output | 6 | Scroll RAM index |
| vsram_wdata | output | 10 | Scroll value |

## Verification
Every result here is registered exactly once. The command, address, step, register pulse, memory strobes and read data all appear in the cycle after the clock edge that captured the bus operation.

The bench drives each operation at a falling edge and holds it for one full cycle. It then samples at the next falling edge, which lies after the single capturing edge and before the following one. One-cycle pulses such as `reg_we` and `vram_we` are therefore observed while they are high.

The bench keeps its own model of the address and step. This lets it show that rejected writes leave the address unchanged and that a register-shaped second word produces no register pulse.

// File: rtl/vid_port_pkg.sv
package vid_port_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } seq_state_t;

    localparam logic [3:0] OP_VRAM_WR  = 4'd1;
    localparam logic [3:0] OP_CRAM_WR  = 4'd3;
    localparam logic [3:0] OP_VSRAM_WR = 4'd5;

    localparam logic [1:0] TAG_REGWR   = 2'b10;
    localparam logic [4:0] REG_MODE_B  = 5'h01;
    localparam logic [4:0] REG_STEP    = 5'h0F;
    localparam int         DMA_EN_BIT  = 4;

    function automatic logic [8:0] pack_colour(input logic [15:0] w);
        return {w[11:9], w[7:5], w[3:1]};
    endfunction

    function automatic logic [15:0] swap_bytes(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/vp_cmd_seq.sv
module vp_cmd_seq
    import vid_port_pkg::*;
#(
    parameter int CMD_W  = 6,
    parameter int ADDR_W = 16,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [15:0]       ctl_word,
    input  logic              clr_pend,
    input  logic              adv,
    output logic [CMD_W-1:0]  cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [STEP_W-1:0] step,
    output logic              reg_we,
    output logic [4:0]        reg_sel,
    output logic [7:0]        reg_data
);

    seq_state_t st, st_nxt;
    logic       is_regwr;

    assign is_regwr = (ctl_word[15:14] == TAG_REGWR);

    always_comb begin
        st_nxt = st;
        unique case (st)
            SEQ_IDLE: if (ctl_wr && !is_regwr) st_nxt = SEQ_HALF;
            SEQ_HALF: if (ctl_wr)              st_nxt = SEQ_IDLE;
        endcase
        if (clr_pend) st_nxt = SEQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEQ_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd      <= '0;
            addr     <= '0;
            step     <= '0;
            reg_we   <= 1'b0;
            reg_sel  <= '0;
            reg_data <= '0;
        end else begin
            reg_we <= 1'b0;
            if (ctl_wr) begin
                unique case (st)
                    SEQ_IDLE: begin
                        if (is_regwr) begin
                            reg_we   <= 1'b1;
                            reg_sel  <= ctl_word[12:8];
                            reg_data <= ctl_word[7:0];
                            if (ctl_word[12:8] == REG_STEP)
                                step <= ctl_word[STEP_W-1:0];
                            if (ctl_word[12:8] == REG_MODE_B && !ctl_word[DMA_EN_BIT])
                                cmd[5] <= 1'b0;
                        end else begin
                            cmd[1:0]  <= ctl_word[15:14];
                            addr[13:0] <= ctl_word[13:0];
                        end
                    end
                    SEQ_HALF: begin
                        cmd[5:2]    <= ctl_word[7:4];
                        addr[15:14] <= ctl_word[1:0];
                    end
                endcase
            end else if (adv) begin
                addr <= addr + ADDR_W'(step);
            end
        end
    end

    assert_clear_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> (st == SEQ_IDLE));

    assert_second_no_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_HALF && ctl_wr) |=> (!reg_we && st == SEQ_IDLE));

    assert_reg_keeps_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(addr));

endmodule

// File: rtl/vp_mem_writer.sv
module vp_mem_writer
    import vid_port_pkg::*;
#(
    parameter int VSRAM_DEPTH = 40,
    parameter int IDX_W       = 6,
    parameter int VADDR_W     = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dat_wr,
    input  logic [15:0]        word,
    input  logic [5:0]         cmd,
    input  logic [15:0]        addr,
    output logic               adv,
    output logic               vram_we,
    output logic [VADDR_W-1:0] vram_addr,
    output logic [15:0]        vram_wdata,
    output logic               cram_we,
    output logic [IDX_W-1:0]   cram_addr,
    output logic [8:0]         cram_wdata,
    output logic               vsram_we,
    output logic [IDX_W-1:0]   vsram_addr,
    output logic [9:0]         vsram_wdata
);

    logic [3:0]       code;
    logic [IDX_W-1:0] idx;
    logic             hit_v, hit_c, hit_s;

    assign code  = cmd[3:0];
    assign idx   = addr[IDX_W:1];
    assign hit_v = dat_wr && (code == OP_VRAM_WR);
    assign hit_c = dat_wr && (code == OP_CRAM_WR);
    assign hit_s = dat_wr && (code == OP_VSRAM_WR) && (int'(idx) < VSRAM_DEPTH);
    assign adv   = hit_v || hit_c || hit_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_we     <= 1'b0;
            vram_addr   <= '0;
            vram_wdata  <= '0;
            cram_we     <= 1'b0;
            cram_addr   <= '0;
            cram_wdata  <= '0;
            vsram_we    <= 1'b0;
            vsram_addr  <= '0;
            vsram_wdata <= '0;
        end else begin
            vram_we  <= hit_v;
            cram_we  <= hit_c;
            vsram_we <= hit_s;
            if (hit_v) begin
                vram_addr  <= addr[15:1];
                vram_wdata <= addr[0] ? swap_bytes(word) : word;
            end
            if (hit_c) begin
                cram_addr  <= idx;
                cram_wdata <= pack_colour(word);
            end
            if (hit_s) begin
                vsram_addr  <= idx;
                vsram_wdata <= word[9:0];
            end
        end
    end

    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vram_we, cram_we, vsram_we}));

    assert_vsram_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vsram_we |-> (int'(vsram_addr) < VSRAM_DEPTH));

endmodule

// File: rtl/vp_read_mux.sv
module vp_read_mux #(
    parameter logic [15:0] STATUS_BASE = 16'h3400,
    parameter int          BUSY_BIT    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_rd,
    input  logic        dat_rd,
    input  logic        dma_active,
    output logic [15:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ctl_rd) begin
            rdata           <= STATUS_BASE;
            rdata[BUSY_BIT] <= dma_active;
        end else if (dat_rd) begin
            rdata <= '0;
        end
    end

    assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> (rdata == (STATUS_BASE | (16'(($past(dma_active))) << BUSY_BIT))));

endmodule

// File: rtl/vid_port_unit.sv
module vid_port_unit
    import vid_port_pkg::*;
#(
    parameter int VSRAM_DEPTH = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_byte,
    input  logic        dma_active,
    output logic [15:0] bus_rdata,
    output logic [5:0]  cmd_code,
    output logic [15:0] acc_addr,
    output logic        reg_we,
    output logic [4:0]  reg_sel,
    output logic [7:0]  reg_data,
    output logic        vram_we,
    output logic [14:0] vram_addr,
    output logic [15:0] vram_wdata,
    output logic        cram_we,
    output logic [5:0]  cram_addr,
    output logic [8:0]  cram_wdata,
    output logic        vsram_we,
    output logic [5:0]  vsram_addr,
    output logic [9:0]  vsram_wdata
);

    logic        in_win, pick_ctl;
    logic        ctl_wr, ctl_rd, dat_wr, dat_rd, clr_pend, adv;
    logic [15:0] word;
    logic [7:0]  step;

    assign in_win   = (bus_addr[4:3] == 2'b00);
    assign pick_ctl = bus_addr[2];
    assign word     = bus_byte ? {bus_wdata[7:0], bus_wdata[7:0]} : bus_wdata;
    assign ctl_wr   = bus_wr && in_win &&  pick_ctl;
    assign dat_wr   = bus_wr && in_win && !pick_ctl;
    assign ctl_rd   = bus_rd && in_win &&  pick_ctl;
    assign dat_rd   = bus_rd && in_win && !pick_ctl;
    assign clr_pend = ctl_rd || dat_rd || dat_wr;

    vp_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_word (word),
        .clr_pend (clr_pend),
        .adv      (adv),
        .cmd      (cmd_code),
        .addr     (acc_addr),
        .step     (step),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_data (reg_data)
    );

    vp_mem_writer #(.VSRAM_DEPTH(VSRAM_DEPTH)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .dat_wr      (dat_wr),
        .word        (word),
        .cmd         (cmd_code),
        .addr        (acc_addr),
        .adv         (adv),
        .vram_we     (vram_we),
        .vram_addr   (vram_addr),
        .vram_wdata  (vram_wdata),
        .cram_we     (cram_we),
        .cram_addr   (cram_addr),
        .cram_wdata  (cram_wdata),
        .vsram_we    (vsram_we),
        .vsram_addr  (vsram_addr),
        .vsram_wdata (vsram_wdata)
    );

    vp_read_mux u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_rd     (ctl_rd),
        .dat_rd     (dat_rd),
        .dma_active (dma_active),
        .rdata      (bus_rdata)
    );

    assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we || cram_we || vsram_we) |-> (acc_addr == $past(acc_addr) + 16'($past(step))));

    assert_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_win) |=> ($stable(acc_addr) && $stable(cmd_code) && !reg_we));

endmodule

// File: tb/tb_vid_port_unit.sv
module tb_vid_port_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0, dma_active = 1'b0;
    logic [15:0] bus_rdata, acc_addr, vram_wdata;
    logic [5:0]  cmd_code, cram_addr, vsram_addr;
    logic        reg_we, vram_we, cram_we, vsram_we;
    logic [4:0]  reg_sel;
    logic [7:0]  reg_data;
    logic [14:0] vram_addr;
    logic [8:0]  cram_wdata;
    logic [9:0]  vsram_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_port_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [4:0] a,
                      input logic [15:0] d, input logic b);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; bus_byte = b;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_byte = 0;
    endtask

    task automatic ctl(input logic [15:0] d); op(1, 0, 5'h04, d, 0); endtask
    task automatic dwr(input logic [15:0] d); op(1, 0, 5'h00, d, 0); endtask

    task automatic t_reset();
        chk("R12 cmd", 32'(cmd_code), 0);
        chk("R12 addr", 32'(acc_addr), 0);
        chk("R12 rdata", 32'(bus_rdata), 0);
        chk("R12 strobes", 32'({reg_we, vram_we, cram_we, vsram_we}), 0);
    endtask

    task automatic t_regwrite();
        ctl(16'h8F02);
        chk("R1 we", 32'(reg_we), 1);
        chk("R1 sel", 32'(reg_sel), 32'h0F);
        chk("R1 data", 32'(reg_data), 32'h02);
        ctl(16'hAF04);
        chk("R1 bit13 sel", 32'(reg_sel), 32'h0F);
        chk("R1 bit13 data", 32'(reg_data), 32'h04);
        ctl(16'h8F02);
        chk("R1 addr kept", 32'(acc_addr), 0);
    endtask

    task automatic t_vram();
        ctl(16'h4000); ctl(16'h0000);
        chk("R2 cmd", 32'(cmd_code), 1);
        dwr(16'h1234);
        chk("R5 we", 32'(vram_we), 1);
        chk("R5 addr", 32'(vram_addr), 0);
        chk("R5 data", 32'(vram_wdata), 32'h1234);
        chk("R8 step", 32'(acc_addr), 2);
        ctl(16'h4001); ctl(16'h0000);
        dwr(16'h1234);
        chk("R5 swap", 32'(vram_wdata), 32'h3412);
        chk("R5 swap addr", 32'(vram_addr), 0);
        chk("R8 odd step", 32'(acc_addr), 3);
        ctl(16'h4000); ctl(16'h0003);
        chk("R3 high addr", 32'(acc_addr), 32'hC000);
        dwr(16'h0001);
        chk("R5 high word", 32'(vram_addr), 32'h6000);
    endtask

    task automatic t_cram();
        ctl(16'hC004); ctl(16'h0000);
        chk("R2 cram cmd", 32'(cmd_code), 3);
        dwr(16'h0A42);
        chk("R6 we", 32'({vram_we, cram_we}), 1);
        chk("R6 idx", 32'(cram_addr), 2);
        chk("R6 pack", 32'(cram_wdata), 32'h151);
        chk("R8 cram step", 32'(acc_addr), 6);
    endtask

    task automatic t_vsram();
        ctl(16'h404E); ctl(16'h0010);
        chk("R3 cmd", 32'(cmd_code), 5);
        dwr(16'hFFFF);
        chk("R7 we", 32'(vsram_we), 1);
        chk("R7 idx", 32'(vsram_addr), 39);
        chk("R7 data", 32'(vsram_wdata), 32'h3FF);
        chk("R8 vs step", 32'(acc_addr), 32'h50);
        dwr(16'h1111);
        chk("R7 limit we", 32'(vsram_we), 0);
        chk("R7 limit addr", 32'(acc_addr), 32'h50);
    endtask

    task automatic t_ignore();
        ctl(16'h0000); ctl(16'h0000);
        dwr(16'hABCD);
        chk("R8 ignored", 32'({vram_we, cram_we, vsram_we}), 0);
        chk("R8 no step", 32'(acc_addr), 0);
        op(1, 0, 5'h0C, 16'h4123, 0);
        chk("R11 outside", 32'(acc_addr), 0);
    endtask

    task automatic t_pending();
        ctl(16'h4000);
        op(0, 1, 5'h06, 16'h0, 0);
        ctl(16'h0010);
        chk("R4 ctl read", 32'(acc_addr), 32'h0010);
        dwr(16'h0000);
        ctl(16'h0020);
        chk("R4 data write", 32'(acc_addr), 32'h0020);
        op(0, 1, 5'h00, 16'h0, 0);
        ctl(16'h4000);
        ctl(16'h8F05);
        chk("R3 no reg", 32'(reg_we), 0);
        chk("R3 addr", 32'(acc_addr), 32'h4000);
    endtask

    task automatic t_status();
        dma_active = 1;
        op(0, 1, 5'h04, 16'h0, 0);
        chk("R9 busy", 32'(bus_rdata), 32'h3402);
        dma_active = 0;
        op(0, 1, 5'h06, 16'h0, 0);
        chk("R9 idle", 32'(bus_rdata), 32'h3400);
        op(0, 1, 5'h02, 16'h0, 0);
        chk("R9 data read", 32'(bus_rdata), 0);
    endtask

    task automatic t_dmaoff();
        ctl(16'h4000); ctl(16'h0080);
        chk("R10 set", 32'(cmd_code), 32'h21);
        ctl(16'h8110);
        chk("R10 enabled", 32'(cmd_code), 32'h21);
        ctl(16'h8100);
        chk("R10 cleared", 32'(cmd_code), 32'h01);
    endtask

    task automatic t_byte();
        ctl(16'h4000); ctl(16'h0000);
        op(1, 0, 5'h01, 16'h005A, 1);
        chk("R11 byte data", 32'(vram_wdata), 32'h5A5A);
        chk("R11 byte addr", 32'(vram_addr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regwrite();
        t_vram();
        t_cram();
        t_vsram();
        t_ignore();
        t_pending();
        t_status();
        t_dmaoff();
        t_byte();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule